// File: doc/BRIEF.md
# Translation Cache with Pinned Entries

This block is a small, fully associative translation cache. It maps a 20-bit virtual page number to a 20-bit physical page number and a 4-bit domain. The lookup path is purely combinational: a page number presented on the lookup port returns hit, physical page and domain in the same cycle. New translations are written through a refill port into the slot chosen by a replacement pointer. After each refill the pointer advances round-robin.

Software can pin translations by setting a pinning base. Slots whose index is below the base are protected:
- a flush-all command leaves them valid;
- the round-robin pointer never wraps into them.

The pinning base and the replacement pointer sit together in one register. That register can be read and written at any time. Software can therefore aim the pointer at a pinned slot to load it, and then raise the base so that the slot stays resident. A flush-by-address command removes the matching translation wherever it lives, pinned or not. One instance serves instruction fetches and a second, separate instance serves data accesses, each with its own register.

Top module: `tlb_lockdown`

## Requirements
- R1: While reset is asserted and after it is released, every slot is invalid (every lookup misses), and the pinning base and replacement pointer read back as 0.
- R2: A refill writes the presented page number, physical page and domain into the slot selected by the replacement pointer. From the next cycle on, a lookup of that page number hits with that physical page and domain.
- R3: After a refill the replacement pointer increments by one. A refill taken with the pointer at 15 sets the pointer to the pinning base instead of 0.
- R4: A register write loads both the pinning base and the replacement pointer. Both values read back from the next cycle on, and they hold until the next refill or register write.
- R5: A replacement pointer below the pinning base may be written. The next refill uses that slot, and the pointer then increments normally from that value.
- R6: Flush-all invalidates every slot whose index is at or above the pinning base. Slots below the base stay valid.
- R7: Flush-by-address invalidates every valid slot whose page number equals the flush address, pinned slots included. Other slots are not affected.
- R8: A lookup hits only when exactly one valid slot matches. If two or more slots match, or if none does, hit is 0 and the physical page and domain outputs are 0.
- R9: Lookup is combinational. The result follows the lookup page number within the same cycle, without a clock edge.
- R10: When a refill and a flush (all or by address) fall in the same cycle, the slot being refilled ends up valid with the new contents.
- R11: When a refill and a register write fall in the same cycle, the refill uses the old pointer, and afterwards the pointer equals the written value rather than the incremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Exactly one valid slot matched |
| lk_ppn | output | 20 | Physical page of the matching slot, 0 on miss |
| lk_dom | output | 4 | Domain of the matching slot, 0 on miss |
| fill_en | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ppn | input | 20 | Refill physical page |
| fill_dom | input | 4 | Refill domain |
| flush_all | input | 1 | Invalidate every slot at or above the pinning base |
| flush_one | input | 1 | Invalidate slots matching flush_vpn |
| flush_vpn | input | 20 | Address for flush_one |
| ldreg_wr | input | 1 | Write strobe for the pinning register |
| ldreg_base_in | input | 4 | New pinning base |
| ldreg_victim_in | input | 4 | New replacement pointer |
| ldreg_base | output | 4 | Current pinning base |
| ldreg_victim | output | 4 | Current replacement pointer |

## Verification
The hardest state to reach from the ports is a duplicate tag, where two valid slots hold the same page number. Round-robin refill never produces it on its own. The stimulus creates one on purpose: it rewinds the pointer through a register write and refills an existing page number into a second slot. It then checks that the lookup misses with zeroed outputs, and that one flush-by-address removes both copies. Wrap-to-base is reached by filling all sixteen slots and then raising the base with the pointer parked at 15. Same-cycle collisions are driven as single combined strobes: refill with flush-all, and refill with a register write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W     = 20;
    localparam int PPN_W     = 20;
    localparam int DOM_W     = 4;
    localparam int N_ENTRIES = 16;
    localparam int IDX_W     = $clog2(N_ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [DOM_W-1:0] dom_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        ppn_t ppn;
        dom_t dom;
    } slot_t;

    typedef struct packed {
        idx_t base;
        idx_t victim;
    } pinreg_t;

    typedef struct packed {
        logic hit;
        ppn_t ppn;
        dom_t dom;
    } look_res_t;

    function automatic idx_t advance_victim(idx_t cur, idx_t base);
        return (cur == LAST_IDX) ? base : idx_t'(cur + 1'b1);
    endfunction
endpackage

// File: rtl/tlb_victim_ctl.sv
module tlb_victim_ctl
    import tlb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fill_en,
    input  logic    reg_wr,
    input  pinreg_t reg_wdata,
    output pinreg_t pin_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= '0;
        end else if (reg_wr) begin
            pin_q <= reg_wdata;
        end else if (fill_en) begin
            pin_q.victim <= advance_victim(pin_q.victim, pin_q.base);
        end
    end

    // R3
    victim_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !reg_wr && pin_q.victim == LAST_IDX) |=> (pin_q.victim == $past(pin_q.base)));

    // R3
    victim_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !reg_wr && pin_q.victim != LAST_IDX) |=> (pin_q.victim == idx_t'($past(pin_q.victim) + 1'b1)));

    // R11
    ldreg_write_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (pin_q == $past(reg_wdata)));

    // R4
    ldreg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr && !fill_en) |=> $stable(pin_q));
endmodule

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
    import tlb_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fill_en,
    input  idx_t                        fill_idx,
    input  vpn_t                        fill_vpn,
    input  ppn_t                        fill_ppn,
    input  dom_t                        fill_dom,
    input  logic                        flush_all,
    input  idx_t                        pin_base,
    input  logic                        flush_one,
    input  vpn_t                        flush_vpn,
    input  vpn_t                        lk_vpn,
    output logic [N_ENTRIES-1:0]        match_vec,
    output ppn_t [N_ENTRIES-1:0]        ppn_tab,
    output dom_t [N_ENTRIES-1:0]        dom_tab
);
    slot_t [N_ENTRIES-1:0] slots;
    logic  [N_ENTRIES-1:0] valid_vec;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        localparam idx_t MY_IDX = idx_t'(i);
        logic sel_fill;
        logic kill_all;
        logic kill_one;

        assign sel_fill = fill_en && (fill_idx == MY_IDX);
        assign kill_all = flush_all && (MY_IDX >= pin_base);
        assign kill_one = flush_one && (slots[i].vpn == flush_vpn);

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (sel_fill) begin
                slots[i] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn, dom: fill_dom};
            end else if (kill_all || kill_one) begin
                slots[i].valid <= 1'b0;
            end
        end

        assign match_vec[i] = slots[i].valid && (slots[i].vpn == lk_vpn);
        assign ppn_tab[i]   = slots[i].ppn;
        assign dom_tab[i]   = slots[i].dom;
        assign valid_vec[i] = slots[i].valid;

        // R6
        pinned_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (flush_all && !flush_one && MY_IDX < pin_base && slots[i].valid) |=> slots[i].valid);

        // R6
        flush_all_chk: assert property (@(posedge clk) disable iff (rst)
            (flush_all && MY_IDX >= pin_base && !(fill_en && fill_idx == MY_IDX)) |=> !slots[i].valid);

        // R10
        fill_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (fill_en && fill_idx == MY_IDX) |=> (slots[i].valid && slots[i].vpn == $past(fill_vpn)));
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (valid_vec == '0));
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
    import tlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ENTRIES-1:0] match_vec,
    input  ppn_t [N_ENTRIES-1:0] ppn_tab,
    input  dom_t [N_ENTRIES-1:0] dom_tab,
    output look_res_t            res
);
    logic single;

    always_comb begin
        single = (match_vec != '0) &&
                 ((match_vec & (match_vec - 1'b1)) == '0);
        res = '0;
        res.hit = single;
        for (int k = 0; k < N_ENTRIES; k++) begin
            if (single && match_vec[k]) begin
                res.ppn = res.ppn | ppn_tab[k];
                res.dom = res.dom | dom_tab[k];
            end
        end
    end

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res.hit |-> (res.ppn == '0 && res.dom == '0));

    // R8
    multi_miss_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(match_vec) > 1) |-> !res.hit);
endmodule

// File: rtl/tlb_lockdown.sv
module tlb_lockdown
    import tlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [VPN_W-1:0]     lk_vpn,
    output logic                 lk_hit,
    output logic [PPN_W-1:0]     lk_ppn,
    output logic [DOM_W-1:0]     lk_dom,
    input  logic                 fill_en,
    input  logic [VPN_W-1:0]     fill_vpn,
    input  logic [PPN_W-1:0]     fill_ppn,
    input  logic [DOM_W-1:0]     fill_dom,
    input  logic                 flush_all,
    input  logic                 flush_one,
    input  logic [VPN_W-1:0]     flush_vpn,
    input  logic                 ldreg_wr,
    input  logic [IDX_W-1:0]     ldreg_base_in,
    input  logic [IDX_W-1:0]     ldreg_victim_in,
    output logic [IDX_W-1:0]     ldreg_base,
    output logic [IDX_W-1:0]     ldreg_victim
);
    pinreg_t               pin_q;
    pinreg_t               pin_wdata;
    logic [N_ENTRIES-1:0]  match_vec;
    ppn_t [N_ENTRIES-1:0]  ppn_tab;
    dom_t [N_ENTRIES-1:0]  dom_tab;
    look_res_t             res;

    assign pin_wdata = '{base: ldreg_base_in, victim: ldreg_victim_in};

    tlb_victim_ctl u_victim (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .reg_wr    (ldreg_wr),
        .reg_wdata (pin_wdata),
        .pin_q     (pin_q)
    );

    tlb_slot_array u_slots (
        .clk       (clk),
        .rst       (rst),
        .fill_en   (fill_en),
        .fill_idx  (pin_q.victim),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .fill_dom  (fill_dom),
        .flush_all (flush_all),
        .pin_base  (pin_q.base),
        .flush_one (flush_one),
        .flush_vpn (flush_vpn),
        .lk_vpn    (lk_vpn),
        .match_vec (match_vec),
        .ppn_tab   (ppn_tab),
        .dom_tab   (dom_tab)
    );

    tlb_hit_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .match_vec (match_vec),
        .ppn_tab   (ppn_tab),
        .dom_tab   (dom_tab),
        .res       (res)
    );

    assign lk_hit       = res.hit;
    assign lk_ppn       = res.ppn;
    assign lk_dom       = res.dom;
    assign ldreg_base   = pin_q.base;
    assign ldreg_victim = pin_q.victim;

    // R2
    fill_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush_one && !flush_all) |=>
            (match_vec[$past(pin_q.victim)] || lk_vpn != $past(fill_vpn)));
endmodule

// File: tb/tlb_lockdown_bench.sv
module tlb_lockdown_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] lk_vpn;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [3:0]  lk_dom;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [19:0] fill_ppn;
    logic [3:0]  fill_dom;
    logic        flush_all;
    logic        flush_one;
    logic [19:0] flush_vpn;
    logic        ldreg_wr;
    logic [3:0]  ldreg_base_in;
    logic [3:0]  ldreg_victim_in;
    logic [3:0]  ldreg_base;
    logic [3:0]  ldreg_victim;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tlb_lockdown u_tlb_lockdown (
        .clk(clk), .rst(rst),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_dom(lk_dom),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dom(fill_dom),
        .flush_all(flush_all), .flush_one(flush_one), .flush_vpn(flush_vpn),
        .ldreg_wr(ldreg_wr), .ldreg_base_in(ldreg_base_in), .ldreg_victim_in(ldreg_victim_in),
        .ldreg_base(ldreg_base), .ldreg_victim(ldreg_victim)
    );

    typedef struct packed {
        logic        is_fill;
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic [3:0]  dom;
        logic        exp_hit;
        logic [19:0] exp_ppn;
        logic [3:0]  exp_dom;
        logic [3:0]  exp_vict;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 20'h00010, 20'hA0010, 4'h3, 1'b1, 20'hA0010, 4'h3, 4'd1},
        '{1'b1, 20'h00020, 20'hA0020, 4'h5, 1'b1, 20'hA0020, 4'h5, 4'd2},
        '{1'b0, 20'h00010, 20'h00000, 4'h0, 1'b1, 20'hA0010, 4'h3, 4'd2},
        '{1'b0, 20'h00030, 20'h00000, 4'h0, 1'b0, 20'h00000, 4'h0, 4'd2},
        '{1'b1, 20'h12345, 20'hFEDCB, 4'hF, 1'b1, 20'hFEDCB, 4'hF, 4'd3},
        '{1'b0, 20'h00020, 20'h00000, 4'h0, 1'b1, 20'hA0020, 4'h5, 4'd3},
        '{1'b0, 20'h12344, 20'h00000, 4'h0, 1'b0, 20'h00000, 4'h0, 4'd3},
        '{1'b1, 20'hFFFFF, 20'h00001, 4'h0, 1'b1, 20'h00001, 4'h0, 4'd4}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fill_en = 1'b0; flush_all = 1'b0; flush_one = 1'b0; ldreg_wr = 1'b0;
        fill_vpn = '0; fill_ppn = '0; fill_dom = '0; flush_vpn = '0;
        ldreg_base_in = '0; ldreg_victim_in = '0; lk_vpn = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] d);
        fill_en = 1'b1; fill_vpn = v; fill_ppn = p; fill_dom = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic ldw(input logic [3:0] b, input logic [3:0] vi);
        ldreg_wr = 1'b1; ldreg_base_in = b; ldreg_victim_in = vi;
        @(negedge clk);
        ldreg_wr = 1'b0;
    endtask

    task automatic flush1(input logic [19:0] v);
        flush_one = 1'b1; flush_vpn = v;
        @(negedge clk);
        flush_one = 1'b0;
    endtask

    task automatic look(input string req, input logic [19:0] v, input logic eh,
                        input logic [19:0] ep, input logic [3:0] ed);
        lk_vpn = v;
        #1;
        chk(req, "hit", 32'(lk_hit), 32'(eh));
        chk(req, "ppn", 32'(lk_ppn), 32'(ep));
        chk(req, "dom", 32'(lk_dom), 32'(ed));
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1", "base", 32'(ldreg_base), 0);
        chk("R1", "victim", 32'(ldreg_victim), 0);
        look("R1", 20'h00000, 1'b0, 20'h0, 4'h0);

        // R2 / R9 vector table: refill then same-cycle lookup
        for (int n = 0; n < NVEC; n++) begin
            lk_vpn = VECS[n].vpn;
            if (VECS[n].is_fill) fill(VECS[n].vpn, VECS[n].ppn, VECS[n].dom);
            look(VECS[n].is_fill ? "R2" : "R9", VECS[n].vpn,
                 VECS[n].exp_hit, VECS[n].exp_ppn, VECS[n].exp_dom);
            chk("R3", "victim", 32'(ldreg_victim), 32'(VECS[n].exp_vict));
        end

        // R3 fill all sixteen slots, pointer wraps to base 0
        do_reset();
        for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'hB0000 + 20'(i), 4'(i));
        chk("R3", "wrap to base 0", 32'(ldreg_victim), 0);

        // R4 register write and readback
        ldw(4'd4, 4'd15);
        chk("R4", "base", 32'(ldreg_base), 4);
        chk("R4", "victim", 32'(ldreg_victim), 15);
        @(negedge clk);
        chk("R4", "victim held", 32'(ldreg_victim), 15);

        // R3 refill at 15 wraps to base 4
        fill(20'h00200, 20'hC0200, 4'h7);
        chk("R3", "wrap to base 4", 32'(ldreg_victim), 4);

        // R6 flush-all keeps slots 0..3
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        look("R6", 20'h00100, 1'b1, 20'hB0000, 4'h0);
        look("R6", 20'h00103, 1'b1, 20'hB0003, 4'h3);
        look("R6", 20'h00104, 1'b0, 20'h0, 4'h0);
        look("R6", 20'h00200, 1'b0, 20'h0, 4'h0);

        // R5 pointer below base loads a pinned slot
        ldw(4'd4, 4'd0);
        fill(20'h00300, 20'hD0300, 4'h9);
        chk("R5", "victim step", 32'(ldreg_victim), 1);
        look("R5", 20'h00300, 1'b1, 20'hD0300, 4'h9);
        look("R5", 20'h00100, 1'b0, 20'h0, 4'h0);

        // R7 flush by address clears a pinned slot only
        flush1(20'h00101);
        look("R7", 20'h00101, 1'b0, 20'h0, 4'h0);
        look("R7", 20'h00102, 1'b1, 20'hB0002, 4'h2);

        // R8 duplicate tag in slots 2 and 5 misses
        ldw(4'd4, 4'd5);
        fill(20'h00102, 20'hE0102, 4'hA);
        look("R8", 20'h00102, 1'b0, 20'h0, 4'h0);
        flush1(20'h00102);
        look("R7", 20'h00102, 1'b0, 20'h0, 4'h0);
        fill(20'h00102, 20'hE0102, 4'hA);
        look("R8", 20'h00102, 1'b1, 20'hE0102, 4'hA);
        chk("R3", "victim", 32'(ldreg_victim), 7);

        // R10 refill concurrent with flush-all
        flush_all = 1'b1;
        fill(20'h00400, 20'hF0400, 4'hB);
        flush_all = 1'b0;
        look("R10", 20'h00400, 1'b1, 20'hF0400, 4'hB);
        look("R6", 20'h00102, 1'b0, 20'h0, 4'h0);
        look("R6", 20'h00300, 1'b1, 20'hD0300, 4'h9);

        // R11 refill concurrent with register write
        ldreg_wr = 1'b1; ldreg_base_in = 4'd4; ldreg_victim_in = 4'd12;
        fill(20'h00500, 20'h10500, 4'hC);
        ldreg_wr = 1'b0;
        chk("R11", "victim", 32'(ldreg_victim), 12);
        look("R11", 20'h00500, 1'b1, 20'h10500, 4'hC);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule